// File: doc/BRIEF.md
# Reference Source Selector with Activity Detect

This block decides which 10 MHz reference feeds a clock distribution chip. It takes three inputs: a preference switch, a level that reports whether the on-board GPS disciplined oscillator is present, and a detect line from the external reference input. It judges the external reference present only when the detect line is seen to change level within a fixed window of samples. At the end of each window it re-evaluates the selection, but only when the switch position or the external-presence result differs from the values used in the last evaluation.

An evaluation has one of three outcomes: internal, external or none. The outcome sets three status lamps and the pulse-per-second source select. For internal and external outcomes it also issues a one-cycle configuration request, together with a table select that tells the downstream serial programmer which register table to load. After reset the block requests the internal table and drives the PPS select to internal. The first window end then always produces an evaluation. All three inputs pass through two-flop synchronisers before use.

The controller has three states. BOOT issues the power-up request and moves to WAIT. WAIT stays in WAIT until a window ends with a trigger (the first window, a switch change or an external-presence change), then moves to APPLY. APPLY drives the outcome and returns to WAIT.

Top module: `refsel_top`

## Requirements
- R1: While reset is held, all lamps are off, `pps_int_o` is 1 and `cfg_req_o` is 0. On the first clock edge after reset, `cfg_req_o` pulses with `cfg_ext_o` = 0 (internal table).
- R2: The external reference counts as present for a window of `WINDOW` synchronised samples if two consecutive samples inside that window differ. The pair that straddles two windows is not counted. The result is updated once, at the end of each window.
- R3: With `pref_ext_i` = 0 (prefer internal), the outcome is internal if GPS is present, otherwise external if the external reference is present, otherwise none.
- R4: With `pref_ext_i` = 1 (prefer external), the outcome is external if the external reference is present, otherwise internal if GPS is present, otherwise none.
- R5: An internal outcome sets top=1, mid=0, bot=1 and `pps_int_o`=1, and pulses `cfg_req_o` with `cfg_ext_o`=0.
- R6: An external outcome sets top=0, mid=1, bot=1 and `pps_int_o`=0, and pulses `cfg_req_o` with `cfg_ext_o`=1.
- R7: A none outcome turns all three lamps off, leaves `pps_int_o` unchanged and issues no request.
- R8: An evaluation takes place only at a window end, and only if it is the first window end after reset or if the synchronised switch or the presence result differs from the last evaluated values. A change in GPS presence alone causes no evaluation.
- R9: Outputs change two clock edges after the window-end indication; `cfg_req_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pref_ext_i | input | 1 | Preference switch: 0 prefers internal, 1 prefers external |
| gps_ok_i | input | 1 | GPS oscillator present level, 1 = present |
| ext_det_i | input | 1 | External reference detect signal (asynchronous) |
| led_top_o | output | 1 | Top status lamp (internal in use) |
| led_mid_o | output | 1 | Middle status lamp (external in use) |
| led_bot_o | output | 1 | Bottom status lamp (some reference in use) |
| pps_int_o | output | 1 | PPS source select: 1 internal, 0 external |
| cfg_req_o | output | 1 | One-cycle request to reprogram the clock chip |
| cfg_ext_o | output | 1 | Table select valid with the request: 0 internal, 1 external |

## Verification
On every cycle, the embedded properties check the following: the request stays one cycle wide, each request carries the lamp and PPS pattern that matches its table select, the PPS select moves only together with a request, and the APPLY state is entered only right after a window end. The presence result may change only at a window end. Only the bench scenarios can show which source is chosen for each combination of preference, GPS and activity. They also show that a GPS change without a switch or presence change leaves the outputs alone, and that a single toggle counts for just the window that holds it. The cycle model in the bench covers these cases.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_INT  = 2'd1,
        SRC_EXT  = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_APPLY = 2'd2
    } ctrl_st_e;

    // Priority of sources for a given preference (R3, R4)
    function automatic src_e pick_src(input logic pref_ext, input logic gps_ok, input logic ext_ok);
        src_e r;
        if (pref_ext) begin
            if (ext_ok)      r = SRC_EXT;
            else if (gps_ok) r = SRC_INT;
            else             r = SRC_NONE;
        end else begin
            if (gps_ok)      r = SRC_INT;
            else if (ext_ok) r = SRC_EXT;
            else             r = SRC_NONE;
        end
        return r;
    endfunction

endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("refsel_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/refsel_activity.sv
module refsel_activity #(
    parameter int WINDOW = 65535
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    output logic win_done_o,
    output logic present_o
);

    localparam int            CW   = $clog2(WINDOW);
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    logic [CW-1:0] cnt_q;
    logic          prev_q;
    logic          seen_q;
    logic          done_q;
    logic          present_q;
    logic          at_last;
    logic          edge_w;

    assign at_last = (cnt_q == LAST);
    // First sample of a window only sets the reference level
    assign edge_w  = (sample_i != prev_q) && (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            prev_q    <= 1'b0;
            seen_q    <= 1'b0;
            done_q    <= 1'b0;
            present_q <= 1'b0;
        end else begin
            prev_q <= sample_i;
            done_q <= at_last;
            if (at_last) begin
                cnt_q     <= '0;
                seen_q    <= 1'b0;
                present_q <= seen_q | edge_w;
            end else begin
                cnt_q  <= cnt_q + CW'(1);
                seen_q <= seen_q | edge_w;
            end
        end
    end

    assign win_done_o = done_q;
    assign present_o  = present_q;

    // R2: one window-end indication per window (WINDOW >= 2)
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R2: presence result only moves together with a window end
    p_present_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> $stable(present_q));

endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
    import refsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pref_ext_i,
    input  logic gps_ok_i,
    input  logic win_done_i,
    input  logic ext_present_i,
    output logic led_top_o,
    output logic led_mid_o,
    output logic led_bot_o,
    output logic pps_int_o,
    output logic cfg_req_o,
    output logic cfg_ext_o
);

    ctrl_st_e state_q, state_d;
    logic     first_q;
    logic     last_sw_q;
    logic     last_ext_q;
    src_e     choice_q;
    logic     trigger;

    logic top_q, mid_q, bot_q, pps_q, req_q, tsel_q;

    assign trigger = win_done_i &&
                     (first_q || (pref_ext_i != last_sw_q) || (ext_present_i != last_ext_q));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = ST_WAIT;
            ST_WAIT:  state_d = trigger ? ST_APPLY : ST_WAIT;
            ST_APPLY: state_d = ST_WAIT;
            default:  state_d = ST_BOOT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // evaluation record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q    <= 1'b1;
            last_sw_q  <= 1'b0;
            last_ext_q <= 1'b0;
            choice_q   <= SRC_NONE;
        end else if (state_q == ST_WAIT && trigger) begin
            first_q    <= 1'b0;
            last_sw_q  <= pref_ext_i;
            last_ext_q <= ext_present_i;
            choice_q   <= pick_src(pref_ext_i, gps_ok_i, ext_present_i);
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q  <= 1'b0;
            mid_q  <= 1'b0;
            bot_q  <= 1'b0;
            pps_q  <= 1'b1;
            req_q  <= 1'b0;
            tsel_q <= 1'b0;
        end else begin
            req_q <= 1'b0;
            unique case (state_q)
                ST_BOOT: begin
                    req_q  <= 1'b1;
                    tsel_q <= 1'b0;
                end
                ST_APPLY: begin
                    unique case (choice_q)
                        SRC_INT: begin
                            top_q  <= 1'b1; mid_q <= 1'b0; bot_q <= 1'b1;
                            pps_q  <= 1'b1;
                            req_q  <= 1'b1; tsel_q <= 1'b0;
                        end
                        SRC_EXT: begin
                            top_q  <= 1'b0; mid_q <= 1'b1; bot_q <= 1'b1;
                            pps_q  <= 1'b0;
                            req_q  <= 1'b1; tsel_q <= 1'b1;
                        end
                        default: begin
                            top_q <= 1'b0; mid_q <= 1'b0; bot_q <= 1'b0;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    assign led_top_o = top_q;
    assign led_mid_o = mid_q;
    assign led_bot_o = bot_q;
    assign pps_int_o = pps_q;
    assign cfg_req_o = req_q;
    assign cfg_ext_o = tsel_q;

    // R9: request is a single-cycle pulse
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);

    // R5: internal request carries the internal lamp/PPS pattern (boot request excepted for lamps)
    p_int_pattern_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !tsel_q && bot_q) |-> (top_q && !mid_q && pps_q));

    // R6: external request carries the external lamp/PPS pattern
    p_ext_pattern_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && tsel_q) |-> (!top_q && mid_q && bot_q && !pps_q));

    // R7: PPS select moves only with a request
    p_pps_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_q |-> $stable(pps_q));

    // R8: evaluation follows a window end
    p_apply_after_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY) |-> $past(win_done_i));

endmodule

// File: rtl/refsel_top.sv
module refsel_top #(
    parameter int WINDOW      = 65535,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pref_ext_i,
    input  logic gps_ok_i,
    input  logic ext_det_i,
    output logic led_top_o,
    output logic led_mid_o,
    output logic led_bot_o,
    output logic pps_int_o,
    output logic cfg_req_o,
    output logic cfg_ext_o
);

    localparam int NIN = 3;

    logic [NIN-1:0] raw_in;
    logic [NIN-1:0] sync_in;
    logic           win_done;
    logic           ext_present;

    assign raw_in = {gps_ok_i, pref_ext_i, ext_det_i};

    refsel_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_in)
    );

    refsel_activity #(.WINDOW(WINDOW)) u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (sync_in[0]),
        .win_done_o (win_done),
        .present_o  (ext_present)
    );

    refsel_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .pref_ext_i    (sync_in[1]),
        .gps_ok_i      (sync_in[2]),
        .win_done_i    (win_done),
        .ext_present_i (ext_present),
        .led_top_o     (led_top_o),
        .led_mid_o     (led_mid_o),
        .led_bot_o     (led_bot_o),
        .pps_int_o     (pps_int_o),
        .cfg_req_o     (cfg_req_o),
        .cfg_ext_o     (cfg_ext_o)
    );

endmodule

// File: tb/refsel_top_tb_top.sv
module refsel_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 16;
    localparam int WDOG       = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pref_ext = 1'b0, gps_ok = 1'b1, ext_det = 1'b0;
    logic top, mid, bot, pps, req, tsel;

    int n_vec = 0, n_bad = 0, cyc = 0;
    string tag = "R1";
    bit tog_en = 0;
    int tog_per = 3;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refsel_top #(.WINDOW(WIN), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .pref_ext_i(pref_ext), .gps_ok_i(gps_ok),
        .ext_det_i(ext_det), .led_top_o(top), .led_mid_o(mid), .led_bot_o(bot),
        .pps_int_o(pps), .cfg_req_o(req), .cfg_ext_o(tsel)
    );

    // behavioural reference model
    bit m_sw[2], m_gp[2], m_dt[2];
    int m_cnt; bit m_prev, m_seen, m_pres, m_done;
    int m_state; // 0 boot, 1 wait, 2 apply
    bit m_first, m_lsw, m_lext; int m_choice; // 0 none 1 int 2 ext
    bit e_top, e_mid, e_bot, e_pps, e_req, e_ext;
    bit prev_req;

    function automatic int choose(bit pe, bit g, bit x);
        if (pe) return x ? 2 : (g ? 1 : 0);
        return g ? 1 : (x ? 2 : 0);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sw = '{0,0}; m_gp = '{0,0}; m_dt = '{0,0};
            m_cnt = 0; m_prev = 0; m_seen = 0; m_pres = 0; m_done = 0;
            m_state = 0; m_first = 1; m_lsw = 0; m_lext = 0; m_choice = 0;
            e_top = 0; e_mid = 0; e_bot = 0; e_pps = 1; e_req = 0; e_ext = 0;
        end else begin
            bit s, edg, n_pres, n_done, trig; int n_cnt;
            // controller sees current synchronised values and activity outputs
            e_req = 0;
            trig = m_done && (m_first || m_sw[1] != m_lsw || m_pres != m_lext);
            case (m_state)
                0: begin e_req = 1; e_ext = 0; m_state = 1; end
                1: if (trig) begin
                       m_choice = choose(m_sw[1], m_gp[1], m_pres);
                       m_first = 0; m_lsw = m_sw[1]; m_lext = m_pres; m_state = 2;
                   end
                default: begin
                    if (m_choice == 1) begin
                        e_top = 1; e_mid = 0; e_bot = 1; e_pps = 1; e_req = 1; e_ext = 0;
                    end else if (m_choice == 2) begin
                        e_top = 0; e_mid = 1; e_bot = 1; e_pps = 0; e_req = 1; e_ext = 1;
                    end else begin
                        e_top = 0; e_mid = 0; e_bot = 0;
                    end
                    m_state = 1;
                end
            endcase
            // activity window
            s = m_dt[1];
            edg = (m_cnt != 0) && (s != m_prev);
            n_done = (m_cnt == WIN-1);
            n_pres = n_done ? (m_seen | edg) : m_pres;
            m_seen = n_done ? 0 : (m_seen | edg);
            n_cnt = n_done ? 0 : m_cnt + 1;
            m_prev = s; m_cnt = n_cnt; m_done = n_done; m_pres = n_pres;
            // synchronisers
            m_sw[1] = m_sw[0]; m_sw[0] = pref_ext;
            m_gp[1] = m_gp[0]; m_gp[0] = gps_ok;
            m_dt[1] = m_dt[0]; m_dt[0] = ext_det;
        end
    end

    task automatic chk(string rq, string nm, logic act, bit exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s [%s] cycle %0d: got %b expected %b", rq, nm, tag, cyc, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        cyc++;
        chk("R5/R6/R7", "led_top", top, e_top);
        chk("R5/R6/R7", "led_mid", mid, e_mid);
        chk("R5/R6/R7", "led_bot", bot, e_bot);
        chk("R5/R6/R7", "pps_int", pps, e_pps);
        chk("R8", "cfg_req", req, e_req);
        if (e_req) chk("R5/R6", "cfg_ext", tsel, e_ext);
        chk("R9", "req_twice", prev_req && req, 1'b0);
        prev_req = req;
        if (tog_en && (cyc % tog_per == 0)) ext_det = ~ext_det;
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // named scenario checks at settled points
    task automatic expect_state(string rq, bit t, bit m, bit b, bit p);
        chk(rq, "settled_top", top, t);
        chk(rq, "settled_mid", mid, m);
        chk(rq, "settled_bot", bot, b);
        chk(rq, "settled_pps", pps, p);
    endtask

    initial begin
        tag = "R1";
        wait_cyc(3);
        expect_state("R1", 0, 0, 0, 1);
        chk("R1", "reset_req", req, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "boot_req", req, 1'b1);
        chk("R1", "boot_table", tsel, 1'b0);
        // R3: prefer internal, GPS present, no activity -> internal
        tag = "R3";
        wait_cyc(3*WIN);
        expect_state("R3", 1, 0, 1, 1);
        // R2: activity appears, presence change re-evaluates, still internal
        tag = "R2"; tog_per = 3; tog_en = 1;
        wait_cyc(3*WIN);
        expect_state("R2", 1, 0, 1, 1);
        // R4: prefer external with activity -> external
        tag = "R4"; pref_ext = 1;
        wait_cyc(3*WIN);
        expect_state("R4", 0, 1, 1, 0);
        // R8: GPS loss alone causes nothing
        tag = "R8"; gps_ok = 0;
        wait_cyc(3*WIN);
        expect_state("R8", 0, 1, 1, 0);
        // R7: activity stops, GPS absent -> none, PPS kept low
        tag = "R7"; tog_en = 0;
        wait_cyc(3*WIN);
        expect_state("R7", 0, 0, 0, 0);
        // R8: GPS returns without switch/presence change -> stays none
        tag = "R8"; gps_ok = 1;
        wait_cyc(3*WIN);
        expect_state("R8", 0, 0, 0, 0);
        // R4: prefer external, no activity, GPS present -> internal
        tag = "R4"; pref_ext = 0; wait_cyc(2*WIN); pref_ext = 1;
        wait_cyc(3*WIN);
        expect_state("R4", 1, 0, 1, 1);
        // R3: prefer internal, no GPS, activity -> external
        tag = "R3"; pref_ext = 0; gps_ok = 0; tog_per = 5; tog_en = 1;
        wait_cyc(3*WIN);
        expect_state("R3", 0, 1, 1, 0);
        // R2: single toggle counts for one window only
        tag = "R2"; tog_en = 0;
        wait_cyc(3*WIN);
        ext_det = ~ext_det;
        wait_cyc(4*WIN);
        expect_state("R2", 0, 0, 0, 0);
        // R2: slow toggling near window length still detected
        tag = "R2"; tog_per = WIN - 3; tog_en = 1;
        wait_cyc(6*WIN);
        tog_en = 0;
        wait_cyc(4*WIN);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule